// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block accepts an incoming Ethernet frame as a stream of bytes marked with start and end flags. It stores the frame in one fixed-size packet buffer in a set layout. At the start of a frame it asks an external allocator for a buffer, in the same cycle. It writes the frame bytes through a byte-wide memory write port. After the last byte it adds zero padding up to the minimum frame size, then an optional CRC-32, then a two-byte trailer and a four-byte header. Last, it pushes the buffer number onto the receive queue and pulses the receive-interrupt set line.

In the stored layout, a 16-bit status word comes first, then a 16-bit byte count, then the even part of the frame. Only the frame's byte pairs are stored as data. When the length is odd, the last byte goes in the trailer next to a control byte, after the CRC. A frame that would not fit in the buffer is abandoned and its buffer is handed back. A soft reset during reception also abandons the frame and hands back its buffer.

The state machine has eight states. IDLE waits for a start flag. DATA stores bytes. SKIP discards the rest of a refused frame. PAD writes zero bytes. CRC writes four checksum bytes. ODD writes the odd byte or a zero. CTRL writes the control byte. HDR writes the header and completes the frame. The transitions are:
- IDLE to DATA on an accepted start.
- IDLE to PAD on an accepted one-byte frame.
- IDLE to SKIP on a refused start.
- DATA to PAD, CRC or ODD on the end flag.
- DATA to SKIP on overflow before the end flag.
- DATA to IDLE on soft reset, or on overflow with the end flag.
- SKIP to IDLE on the end flag.
- PAD to CRC or ODD when the minimum size is reached.
- CRC to ODD after four bytes.
- ODD to CTRL, then CTRL to HDR.
- HDR to IDLE after four bytes.

Top module: `rx_frame_writer`

## Requirements
- R1: A frame is taken only when `rx_en`=1, `soft_rst`=0 and `alloc_gnt`=1 in the cycle its first byte (`rx_sof`=1) arrives. `alloc_req` is asserted only in that cycle, in IDLE, with `rx_en`=1 and `soft_rst`=0. A refused frame causes no memory write and no queue push, and its remaining bytes are discarded.
- R2: Header layout: address 0 holds the status word low byte and address 1 its high byte. Address 2 holds the stored byte count low byte and address 3 its high byte.
- R3: Status bit 12 (bit 4 of address 1) is set when the final frame length is odd. Bit 11 (bit 3 of address 1) is set when the padded length exceeds LONG_FRAME. All other status bits are zero.
- R4: The even part of the frame (length rounded down to even) is stored from address 4 upward, in arrival order.
- R5: A frame shorter than MIN_FRAME bytes is extended with zero bytes to MIN_FRAME. The padding counts in the length and in the CRC.
- R6: Unless `strip_crc`=1 at the start byte, a CRC-32 over all padded frame bytes follows the data, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, an initial value of all ones, and a final inversion.
- R7: After the CRC, or after the data when the CRC is stripped, come two bytes. The first is the odd last byte, or 0x00 when the length is even. The second is the control byte: 0x60 for odd, 0x40 for even. The stored count is even part + 6 (+4 with CRC).
- R8: A frame whose stored count would exceed BUF_BYTES is abandoned. Its buffer is returned exactly once via `rel_valid`/`rel_num`, no queue push occurs, and no write reaches an address at or above BUF_BYTES.
- R9: A stored frame gives exactly one `q_push` pulse, with `q_num` equal to the buffer. This pulse comes together with `rx_irq` and with the final header write (address 3).
- R10: `soft_rst`=1 while a frame's data is being received abandons the frame and returns its buffer without a push.
- R11: Bytes that arrive in IDLE without `rx_sof` are ignored and cause no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_byte | input | 8 | Frame byte |
| rx_en | input | 1 | Receive enable |
| soft_rst | input | 1 | Soft reset active |
| strip_crc | input | 1 | Omit CRC from stored frame |
| alloc_req | output | 1 | Buffer request (same-cycle grant) |
| alloc_gnt | input | 1 | Buffer granted |
| alloc_num | input | $clog2(NUM_BUFS) | Granted buffer number |
| mem_we | output | 1 | Buffer memory write enable |
| mem_buf | output | $clog2(NUM_BUFS) | Buffer number of write |
| mem_addr | output | $clog2(BUF_BYTES) | Byte address in buffer |
| mem_wdata | output | 8 | Write data |
| q_push | output | 1 | Push buffer onto receive queue |
| q_num | output | $clog2(NUM_BUFS) | Buffer number pushed |
| rel_valid | output | 1 | Return buffer to allocator |
| rel_num | output | $clog2(NUM_BUFS) | Buffer number returned |
| rx_irq | output | 1 | Receive-interrupt set pulse |

## Verification
The bench builds the block with NUM_BUFS=4, BUF_BYTES=128, MIN_FRAME=64 and LONG_FRAME=100. With these values the overflow boundary falls at frame lengths near 120 bytes, with and without CRC. The too-long status bit is reached with frames of a little over 100 bytes. Short frames still exercise padding, including a 63-byte frame whose padding turns it even. Four buffers let the bench model a full allocator and check that buffers come back after abandoned frames.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DATA,
        ST_SKIP,
        ST_PAD,
        ST_CRC,
        ST_ODD,
        ST_CTRL,
        ST_HDR
    } rxw_state_e;

    localparam logic [7:0]  CTRL_ODD_BYTE  = 8'h60;
    localparam logic [7:0]  CTRL_EVEN_BYTE = 8'h40;
    localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB88320;

    function automatic logic [31:0] crc_step(input logic [31:0] cur, input logic [7:0] din);
        logic [31:0] c;
        c = cur ^ {24'h0, din};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rxw_crc32.sv
module rxw_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] crc_out
);
    import rxw_pkg::*;

    logic [31:0] acc;
    logic [31:0] base;

    always_comb base = init ? 32'hFFFF_FFFF : acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= 32'hFFFF_FFFF;
        end else if (upd) begin
            acc <= crc_step(base, din);
        end else if (init) begin
            acc <= 32'hFFFF_FFFF;
        end
    end

    assign crc_out = ~acc;

    // R6: a fresh start with no byte leaves the inverted all-ones value
    a_r6_init_value: assert property (@(posedge clk) disable iff (!rst_n)
        (init && !upd) |=> (crc_out == 32'h0));

endmodule

// File: rtl/rxw_len.sv
module rxw_len #(
    parameter int BUF_BYTES  = 2048,
    parameter int LONG_FRAME = 1518,
    parameter int CW         = 12
) (
    input  logic [CW-1:0] cnt,
    input  logic          crc_on,
    output logic [CW-1:0] even_cnt,
    output logic [CW-1:0] stored_cnt,
    output logic [CW-1:0] trl_base,
    output logic          next_over,
    output logic          odd,
    output logic          too_long
);
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] even_inc;
    logic [CW-1:0] crc_bytes;

    always_comb begin
        crc_bytes  = crc_on ? CW'(4) : CW'(0);
        cnt_inc    = cnt + CW'(1);
        even_inc   = {cnt_inc[CW-1:1], 1'b0};
        even_cnt   = {cnt[CW-1:1], 1'b0};
        stored_cnt = even_cnt + CW'(6) + crc_bytes;
        trl_base   = CW'(4) + even_cnt + crc_bytes;
        next_over  = (even_inc + CW'(6) + crc_bytes) > CW'(BUF_BYTES);
        odd        = cnt[0];
        too_long   = cnt > CW'(LONG_FRAME);
    end

endmodule

// File: rtl/rx_frame_writer.sv
module rx_frame_writer #(
    parameter int NUM_BUFS   = 4,
    parameter int BUF_BYTES  = 2048,
    parameter int MIN_FRAME  = 64,
    parameter int LONG_FRAME = 1518,
    localparam int NBW = $clog2(NUM_BUFS),
    localparam int AW  = $clog2(BUF_BYTES),
    localparam int CW  = AW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_valid,
    input  logic           rx_sof,
    input  logic           rx_eof,
    input  logic [7:0]     rx_byte,
    input  logic           rx_en,
    input  logic           soft_rst,
    input  logic           strip_crc,
    output logic           alloc_req,
    input  logic           alloc_gnt,
    input  logic [NBW-1:0] alloc_num,
    output logic           mem_we,
    output logic [NBW-1:0] mem_buf,
    output logic [AW-1:0]  mem_addr,
    output logic [7:0]     mem_wdata,
    output logic           q_push,
    output logic [NBW-1:0] q_num,
    output logic           rel_valid,
    output logic [NBW-1:0] rel_num,
    output logic           rx_irq
);
    import rxw_pkg::*;

    rxw_state_e     state, state_n;
    logic [NBW-1:0] buf_num;
    logic [CW-1:0]  nbytes;
    logic           crc_on;
    logic [7:0]     last_byte;
    logic [1:0]     idx;

    logic           take;
    logic           data_wr;
    logic           crc_init, crc_upd;
    logic [7:0]     crc_din;
    logic [31:0]    crc_val;

    logic [CW-1:0]  even_cnt, stored_cnt, trl_base;
    logic           next_over, is_odd, is_long;
    logic [15:0]    status_w;
    logic [15:0]    count_w;

    rxw_len #(
        .BUF_BYTES (BUF_BYTES),
        .LONG_FRAME(LONG_FRAME),
        .CW        (CW)
    ) u_len (
        .cnt       (nbytes),
        .crc_on    (crc_on),
        .even_cnt  (even_cnt),
        .stored_cnt(stored_cnt),
        .trl_base  (trl_base),
        .next_over (next_over),
        .odd       (is_odd),
        .too_long  (is_long)
    );

    rxw_crc32 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (crc_init),
        .upd    (crc_upd),
        .din    (crc_din),
        .crc_out(crc_val)
    );

    always_comb begin
        alloc_req = (state == ST_IDLE) && rx_valid && rx_sof && rx_en && !soft_rst;
        take      = alloc_req && alloc_gnt;
        data_wr   = (state == ST_DATA) && rx_valid && !soft_rst && !next_over;
        crc_init  = take;
        crc_upd   = take || data_wr || (state == ST_PAD);
        crc_din   = (state == ST_PAD) ? 8'h00 : rx_byte;
        status_w  = 16'({is_odd, is_long}) << 11;
        count_w   = 16'(stored_cnt);
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (rx_valid && rx_sof) begin
                    if (take) begin
                        if (!rx_eof)                         state_n = ST_DATA;
                        else if (MIN_FRAME > 1)              state_n = ST_PAD;
                        else                                 state_n = strip_crc ? ST_ODD : ST_CRC;
                    end else if (!rx_eof) begin
                        state_n = ST_SKIP;
                    end
                end
            end
            ST_DATA: begin
                if (soft_rst) begin
                    state_n = ST_IDLE;
                end else if (rx_valid) begin
                    if (next_over)                           state_n = rx_eof ? ST_IDLE : ST_SKIP;
                    else if (rx_eof) begin
                        if ((nbytes + CW'(1)) < CW'(MIN_FRAME)) state_n = ST_PAD;
                        else                                 state_n = crc_on ? ST_CRC : ST_ODD;
                    end
                end
            end
            ST_SKIP: if (rx_valid && rx_eof) state_n = ST_IDLE;
            ST_PAD:  if ((nbytes + CW'(1)) >= CW'(MIN_FRAME)) state_n = crc_on ? ST_CRC : ST_ODD;
            ST_CRC:  if (idx == 2'd3) state_n = ST_ODD;
            ST_ODD:  state_n = ST_CTRL;
            ST_CTRL: state_n = ST_HDR;
            ST_HDR:  if (idx == 2'd3) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= 2'd0;
        end else begin
            state <= state_n;
            idx   <= (state_n != state) ? 2'd0 : idx + 2'd1;
        end
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_num   <= '0;
            nbytes    <= '0;
            crc_on    <= 1'b0;
            last_byte <= 8'h00;
            mem_we    <= 1'b0;
            mem_buf   <= '0;
            mem_addr  <= '0;
            mem_wdata <= 8'h00;
            q_push    <= 1'b0;
            q_num     <= '0;
            rel_valid <= 1'b0;
            rel_num   <= '0;
            rx_irq    <= 1'b0;
        end else begin
            mem_we    <= 1'b0;
            q_push    <= 1'b0;
            rel_valid <= 1'b0;
            rx_irq    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        buf_num   <= alloc_num;
                        crc_on    <= !strip_crc;
                        nbytes    <= CW'(1);
                        last_byte <= rx_byte;
                        mem_we    <= 1'b1;
                        mem_buf   <= alloc_num;
                        mem_addr  <= AW'(4);
                        mem_wdata <= rx_byte;
                    end
                end
                ST_DATA: begin
                    if (soft_rst || (rx_valid && next_over)) begin
                        rel_valid <= 1'b1;
                        rel_num   <= buf_num;
                    end else if (rx_valid) begin
                        nbytes    <= nbytes + CW'(1);
                        last_byte <= rx_byte;
                        mem_we    <= 1'b1;
                        mem_buf   <= buf_num;
                        mem_addr  <= AW'(nbytes + CW'(4));
                        mem_wdata <= rx_byte;
                    end
                end
                ST_SKIP: begin
                end
                ST_PAD: begin
                    nbytes    <= nbytes + CW'(1);
                    mem_we    <= 1'b1;
                    mem_buf   <= buf_num;
                    mem_addr  <= AW'(nbytes + CW'(4));
                    mem_wdata <= 8'h00;
                end
                ST_CRC: begin
                    mem_we    <= 1'b1;
                    mem_buf   <= buf_num;
                    mem_addr  <= AW'(even_cnt + CW'(4) + CW'(idx));
                    mem_wdata <= crc_val[8*idx +: 8];
                end
                ST_ODD: begin
                    mem_we    <= 1'b1;
                    mem_buf   <= buf_num;
                    mem_addr  <= AW'(trl_base);
                    mem_wdata <= is_odd ? last_byte : 8'h00;
                end
                ST_CTRL: begin
                    mem_we    <= 1'b1;
                    mem_buf   <= buf_num;
                    mem_addr  <= AW'(trl_base + CW'(1));
                    mem_wdata <= is_odd ? CTRL_ODD_BYTE : CTRL_EVEN_BYTE;
                end
                ST_HDR: begin
                    mem_we   <= 1'b1;
                    mem_buf  <= buf_num;
                    mem_addr <= AW'(idx);
                    unique case (idx)
                        2'd0:    mem_wdata <= status_w[7:0];
                        2'd1:    mem_wdata <= status_w[15:8];
                        2'd2:    mem_wdata <= count_w[7:0];
                        default: mem_wdata <= count_w[15:8];
                    endcase
                    if (idx == 2'd3) begin
                        q_push <= 1'b1;
                        q_num  <= buf_num;
                        rx_irq <= 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // R1: allocation is only requested while idle, enabled and out of soft reset
    a_r1_alloc_gated: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> (rx_en && !soft_rst && state == ST_IDLE));

    // R8: a data byte is only written where the full trailer still fits
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |-> (int'(nbytes) + 4 < BUF_BYTES));

    // R8: a frame is either queued or returned, never both at once
    a_r8_push_xor_release: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_push && rel_valid));

    // R9: completion comes with the interrupt and the last header byte
    a_r9_push_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> (rx_irq && mem_we && mem_addr == AW'(3) && mem_buf == q_num));

    // R7: the control byte written one cycle after CTRL takes one of two codes
    a_r7_ctrl_code: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_CTRL && state == ST_HDR) |->
            (mem_we && (mem_wdata == CTRL_ODD_BYTE || mem_wdata == CTRL_EVEN_BYTE)));

endmodule

// File: tb/rx_frame_writer_bench.sv
module rx_frame_writer_bench;

    localparam int NB    = 4;
    localparam int BUFB  = 128;
    localparam int MINF  = 64;
    localparam int LONGF = 100;
    localparam int NBW   = $clog2(NB);
    localparam int AW    = $clog2(BUFB);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]     rx_byte = 8'h00;
    logic           rx_en = 1'b1, soft_rst = 1'b0, strip_crc = 1'b0;
    logic           alloc_req, alloc_gnt;
    logic [NBW-1:0] alloc_num;
    logic           mem_we;
    logic [NBW-1:0] mem_buf;
    logic [AW-1:0]  mem_addr;
    logic [7:0]     mem_wdata;
    logic           q_push, rel_valid, rx_irq;
    logic [NBW-1:0] q_num, rel_num;

    always #5 clk = ~clk;

    rx_frame_writer #(
        .NUM_BUFS(NB), .BUF_BYTES(BUFB), .MIN_FRAME(MINF), .LONG_FRAME(LONGF)
    ) u_rx_frame_writer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_byte(rx_byte), .rx_en(rx_en), .soft_rst(soft_rst), .strip_crc(strip_crc),
        .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_num(alloc_num),
        .mem_we(mem_we), .mem_buf(mem_buf), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .q_push(q_push), .q_num(q_num), .rel_valid(rel_valid), .rel_num(rel_num),
        .rx_irq(rx_irq)
    );

    // allocator and memory model
    logic [NB-1:0]  used = '0;
    logic [NB-1:0]  free_mask = '0;
    logic           force_full = 1'b0;
    logic           clr_mem = 1'b0;
    logic [7:0]     bmem [NB][BUFB];
    int             push_cnt = 0, rel_cnt = 0, wr_cnt = 0, req_cnt = 0;
    int             hi_addr_wr = 0;
    logic [NBW-1:0] last_push = '0;
    logic           last_irq = 1'b0;

    always_comb begin
        alloc_num = '0;
        for (int i = NB - 1; i >= 0; i--) if (!used[i]) alloc_num = NBW'(i);
        alloc_gnt = !force_full && (used != {NB{1'b1}});
    end

    always @(posedge clk) begin
        logic [NB-1:0] nu;
        nu = used & ~free_mask;
        if (alloc_req && alloc_gnt) nu[alloc_num] = 1'b1;
        if (rel_valid) nu[rel_num] = 1'b0;
        used <= nu;
        if (alloc_req) req_cnt <= req_cnt + 1;
        if (q_push) begin
            push_cnt  <= push_cnt + 1;
            last_push <= q_num;
            last_irq  <= rx_irq;
        end
        if (rel_valid) rel_cnt <= rel_cnt + 1;
        if (clr_mem) begin
            for (int b = 0; b < NB; b++)
                for (int a = 0; a < BUFB; a++) bmem[b][a] <= 8'hA5;
        end else if (mem_we) begin
            wr_cnt <= wr_cnt + 1;
            bmem[mem_buf][mem_addr] <= mem_wdata;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fb(input logic [7:0] seed, input int k);
        return seed + 8'(k * 37);
    endfunction

    function automatic logic [31:0] ref_crc(input logic [7:0] seed, input int len, input int p);
        logic [31:0] c;
        logic [7:0]  d;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < p; k++) begin
            d = (k < len) ? fb(seed, k) : 8'h00;
            c = c ^ {24'h0, d};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic send(input int len, input logic [7:0] seed);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (k == 0);
            rx_eof   = (k == len - 1);
            rx_byte  = fb(seed, k);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic release_buf(input logic [NBW-1:0] b);
        @(negedge clk);
        free_mask = '0;
        free_mask[b] = 1'b1;
        @(negedge clk);
        free_mask = '0;
    endtask

    task automatic clear_mem();
        @(negedge clk); clr_mem = 1'b1;
        @(negedge clk); clr_mem = 1'b0;
    endtask

    task automatic run_frame(input int len, input bit strip_v, input logic [7:0] seed);
        int p, e, c, cnt, p0, r0, hb, db, cb, tb;
        bit odd, lng, rej;
        logic [31:0] crc;
        logic [7:0]  ex, ac;
        logic [NBW-1:0] b;
        p   = (len < MINF) ? MINF : len;
        odd = p[0];
        e   = p & ~1;
        c   = strip_v ? 0 : 4;
        cnt = e + 6 + c;
        rej = cnt > BUFB;
        lng = p > LONGF;
        crc = ref_crc(seed, len, p);
        clear_mem();
        strip_crc = strip_v;
        p0 = push_cnt; r0 = rel_cnt;
        send(len, seed);
        repeat (100) @(negedge clk);
        if (rej) begin
            chk(push_cnt == p0, "R8", "no push on oversize", push_cnt - p0, 0);
            chk(rel_cnt == r0 + 1, "R8", "single release", rel_cnt - r0, 1);
            chk(used == '0, "R8", "buffer returned", used, 0);
        end else begin
            chk(push_cnt == p0 + 1 && last_irq, "R9", "push with irq", push_cnt - p0, 1);
            chk(used == (NB'(1) << last_push), "R9", "pushed buffer held", used, NB'(1) << last_push);
            b = last_push;
            hb = 0; db = 0; cb = 0; tb = 0;
            for (int a = 0; a < cnt; a++) begin
                if (a == 0)      ex = 8'h00;
                else if (a == 1) ex = {3'b000, odd, lng, 3'b000};
                else if (a == 2) ex = 8'(cnt);
                else if (a == 3) ex = 8'(cnt >> 8);
                else if (a < 4 + e) ex = (a - 4 < len) ? fb(seed, a - 4) : 8'h00;
                else if (a < 4 + e + c) ex = crc[8*(a-4-e) +: 8];
                else if (a == 4 + e + c) ex = odd ? fb(seed, len - 1) : 8'h00;
                else ex = odd ? 8'h60 : 8'h40;
                ac = bmem[b][a];
                if (ac != ex) begin
                    if (a < 4) hb++;
                    else if (a < 4 + e) db++;
                    else if (a < 4 + e + c) cb++;
                    else tb++;
                    $display("  byte %0d len %0d: got %0h want %0h", a, len, ac, ex);
                end
            end
            chk(hb == 0, "R2", "header bytes wrong (R3 status)", hb, 0);
            chk(db == 0, (len < MINF) ? "R5" : "R4", "data bytes wrong", db, 0);
            chk(cb == 0, "R6", "crc bytes wrong", cb, 0);
            chk(tb == 0, "R7", "trailer bytes wrong", tb, 0);
            release_buf(b);
        end
    endtask

    // {length, strip, seed}
    localparam int NV = 12;
    localparam logic [31:0] VEC [NV] = '{
        {16'd64,  8'd0, 8'h11},   // exact minimum, CRC kept
        {16'd65,  8'd0, 8'h22},   // odd frame
        {16'd10,  8'd0, 8'h33},   // short, padded
        {16'd63,  8'd1, 8'h44},   // odd short, padding makes it even
        {16'd101, 8'd0, 8'h55},   // too-long flag
        {16'd117, 8'd1, 8'h66},   // odd, stripped
        {16'd118, 8'd0, 8'h77},   // fills buffer exactly
        {16'd119, 8'd0, 8'h88},   // odd, fills exactly
        {16'd120, 8'd0, 8'h99},   // one pair too many
        {16'd123, 8'd1, 8'hAA},   // stripped, fills exactly
        {16'd124, 8'd1, 8'hBB},   // stripped, oversize
        {16'd1,   8'd0, 8'hCC}    // single byte
    };

    initial begin
        int w0, q0, r0, a0;
        repeat (3) @(negedge clk);
        chk(!mem_we && !q_push && !rel_valid && !rx_irq && !alloc_req, "R1",
            "reset outputs idle", {mem_we, q_push, rel_valid, rx_irq}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++)
            run_frame(int'(VEC[v][31:16]), VEC[v][8], VEC[v][7:0]);

        // R1: receive disabled
        w0 = wr_cnt; q0 = push_cnt; a0 = req_cnt;
        rx_en = 1'b0;
        send(70, 8'h01);
        repeat (10) @(negedge clk);
        chk(wr_cnt == w0 && push_cnt == q0 && req_cnt == a0, "R1", "disabled frame dropped",
            wr_cnt - w0, 0);
        rx_en = 1'b1;

        // R1: soft reset at start
        soft_rst = 1'b1;
        send(70, 8'h02);
        repeat (10) @(negedge clk);
        chk(wr_cnt == w0 && push_cnt == q0 && req_cnt == a0, "R1", "soft-reset frame dropped",
            wr_cnt - w0, 0);
        soft_rst = 1'b0;

        // R1: no buffer available
        force_full = 1'b1;
        send(70, 8'h03);
        repeat (10) @(negedge clk);
        chk(wr_cnt == w0 && push_cnt == q0 && used == '0, "R1", "no-buffer frame dropped",
            wr_cnt - w0, 0);
        chk(req_cnt == a0 + 1, "R1", "single request when full", req_cnt - a0, 1);
        force_full = 1'b0;

        // R11: stray bytes without start flag
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (k == 4); rx_byte = 8'(k);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0;
        repeat (5) @(negedge clk);
        chk(wr_cnt == w0 && req_cnt == a0 + 1, "R11", "stray bytes ignored", wr_cnt - w0, 0);

        // R10: soft reset in the middle of a frame
        q0 = push_cnt; r0 = rel_cnt;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (k == 0); rx_eof = (k == 19); rx_byte = 8'(k);
            soft_rst = (k == 10);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0; soft_rst = 1'b0;
        repeat (80) @(negedge clk);
        chk(push_cnt == q0, "R10", "no push after abort", push_cnt - q0, 0);
        chk(rel_cnt == r0 + 1 && used == '0, "R10", "buffer returned after abort",
            rel_cnt - r0, 1);

        // recovery frame after abort
        run_frame(66, 1'b0, 8'hDD);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule